// File: doc/BRIEF.md
# Page-Flash Operation Sequencer

This block sits behind the command front end of a page-organised flash model and decides what each accepted byte means. It receives three kinds of byte cycles: command, address and read strobe. From these it runs page read transfers, page program, block erase, reset, status output and identification output. It drives an active-low ready/busy line. Each busy period lasts a number of clock cycles that is set by a parameter, so program, erase, read transfer and the reset recoveries are modelled as fixed-length waits.

The sequencer enforces the acceptance rules of the command set. While busy, it accepts only the status and reset commands. After a program setup, it accepts only the program confirm or a reset. When write-protect is low, no program or erase can start, and one that is already running stops. A repeated reset during a reset recovery is dropped.

Data bytes for a program go straight to the page buffer beside this block and never enter the sequencer. The cell array is a stub. At the end of a program or erase it reports pass or fail from an injection input. In read mode, the byte it returns for column `c` is `c[7:0] XOR (c >> 8)`.

Top module: `flseq_top`

## Requirements
- R1: After synchronous reset, `rb_n` is 1, the block is in read mode at column 0 (so `rd_data` is 00h), and no operation is pending.
- R2: The program sequence is 80h, then three address cycles, then 10h with `wp_n` high. After the 10h edge, `rb_n` is 0 for exactly `T_PROG` cycles. The fail flag then takes the value of `fail_inject` sampled in the last busy cycle.
- R3: The erase sequence is 60h, then two address cycles, then D0h with `wp_n` high. After the D0h edge, `rb_n` is 0 for exactly `T_ERASE` cycles. A D0h that arrives without this setup is ignored.
- R4: A read sequence is a read command followed by three address cycles. After the third address cycle, `rb_n` is 0 for `T_READ` cycles. The start column depends on the command: 00h starts at the first address byte, 01h starts at 256 plus that byte, and 50h starts at 512 plus its low four bits. Each `rd_en` in read mode moves the column up by one, and the column stops at the last column, 527.
- R5: While `rb_n` is 0, only 70h and FFh are acted on. Every other command, and every address cycle, has no effect on the busy time, the column or the output mode.
- R6: After 80h, any command other than 10h or FFh is discarded and cancels the program. A later 10h then starts nothing.
- R7: The status byte has bit 7 equal to `wp_n`, bit 6 set to 1 when ready, and bit 0 set to 1 for fail. Bit 0 reads 0 while busy. Bits 5 to 1 are always 0.
- R8: After 70h, `rd_data` is the status byte and `rd_en` does not move the column. Only 00h returns to read mode, and it resumes at the unchanged column without any address cycles.
- R9: An accepted FFh clears the fail flag and starts a busy period of `T_RST_PROG` cycles during a program, `T_RST_ERASE` cycles during an erase, and `T_RST_READ` cycles otherwise.
- R10: An FFh that arrives while a reset is in progress is ignored. An FFh that arrives after `rb_n` has returned to 1 is honoured.
- R11: 90h followed by an address byte of 00h enters identification mode. Reads then give 98h, then 73h, then 00h.
- R12: With `wp_n` low, a program or erase confirm starts nothing. If `wp_n` goes low during a program or erase, `rb_n` returns to 1 one cycle later and the fail flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | `bus_in` carries a command byte this cycle |
| addr_we | input | 1 | `bus_in` carries an address byte this cycle |
| bus_in | input | 8 | Command or address byte |
| rd_en | input | 1 | Consume the current output byte |
| wp_n | input | 1 | Write-protect, active low |
| fail_inject | input | 1 | Array stub result at program/erase completion (1 = fail) |
| rd_data | output | 8 | Current output byte (array stub, status or identification) |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The ready/busy line falls in the first cycle after the edge that accepts the starting byte. It stays low for exactly the parameter's number of cycles. The bench therefore counts low cycles from the half-cycle after that edge and compares the count with the parameter. The status, identification and array bytes depend combinationally on the registered mode, column and flags, so each one is due in the half-cycle after the edge that changed them. Every comparison is taken at a falling clock edge. Stimuli that must be ignored are issued while the bench counts the busy cycles, so the total length shows whether any of them restarted or shortened the wait.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PROG_ADDR,
        PH_PROG_DATA,
        PH_ERASE_ADDR,
        PH_ERASE_CONF,
        PH_READ_ADDR,
        PH_ID_ADDR
    } phase_e;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_READ,
        BK_PROG,
        BK_ERASE,
        BK_RESET
    } busy_e;

    typedef enum logic [1:0] {
        OM_READ,
        OM_STATUS,
        OM_ID
    } outm_e;

    typedef enum logic [1:0] {
        RG_LOW,
        RG_HIGH,
        RG_SPARE
    } region_e;

    localparam logic [7:0] OPC_RD_LOW    = 8'h00;
    localparam logic [7:0] OPC_RD_HIGH   = 8'h01;
    localparam logic [7:0] OPC_RD_SPARE  = 8'h50;
    localparam logic [7:0] OPC_PGM_SETUP = 8'h80;
    localparam logic [7:0] OPC_PGM_GO    = 8'h10;
    localparam logic [7:0] OPC_ERS_SETUP = 8'h60;
    localparam logic [7:0] OPC_ERS_GO    = 8'hD0;
    localparam logic [7:0] OPC_STATUS    = 8'h70;
    localparam logic [7:0] OPC_IDENT     = 8'h90;
    localparam logic [7:0] OPC_RESET     = 8'hFF;

    localparam logic [7:0] IDENT_MAKER   = 8'h98;
    localparam logic [7:0] IDENT_DEVICE  = 8'h73;

    function automatic logic [7:0] pack_status(logic wp_n, logic ready, logic fail);
        return {wp_n, ready, 5'b00000, fail & ready};
    endfunction

    function automatic logic allowed_when_busy(logic [7:0] opc);
        return (opc == OPC_STATUS) || (opc == OPC_RESET);
    endfunction

endpackage

// File: rtl/flseq_timer.sv
module flseq_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flseq_colptr.sv
module flseq_colptr #(
    parameter int COL_W = 10,
    parameter int LAST  = 527
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] load_val,
    input  logic             adv,
    output logic [COL_W-1:0] col
);
    localparam logic [COL_W-1:0] LAST_C = COL_W'(LAST);

    always_ff @(posedge clk) begin
        if (rst)
            col <= '0;
        else if (load)
            col <= (load_val > LAST_C) ? LAST_C : load_val;
        else if (adv && col != LAST_C)
            col <= col + 1'b1;
    end
endmodule

// File: rtl/flseq_status.sv
module flseq_status
    import flseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic       upd_val,
    input  logic       wp_n,
    input  logic       ready,
    output logic [7:0] stat_byte
);
    logic fail_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            fail_q <= 1'b0;
        else if (upd)
            fail_q <= upd_val;
    end

    assign stat_byte = pack_status(wp_n, ready, fail_q);
endmodule

// File: rtl/flseq_top.sv
module flseq_top
    import flseq_pkg::*;
#(
    parameter int PAGE_BYTES     = 528,
    parameter int MAIN_BYTES     = 512,
    parameter int PAGE_ADDR_CYC  = 3,
    parameter int BLOCK_ADDR_CYC = 2,
    parameter int CNT_W          = 20,
    parameter int T_READ         = 6250,
    parameter int T_PROG         = 50000,
    parameter int T_ERASE        = 500000,
    parameter int T_RST_READ     = 1500,
    parameter int T_RST_PROG     = 2500,
    parameter int T_RST_ERASE    = 125000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_we,
    input  logic       addr_we,
    input  logic [7:0] bus_in,
    input  logic       rd_en,
    input  logic       wp_n,
    input  logic       fail_inject,
    output logic [7:0] rd_data,
    output logic       rb_n
);
    localparam int COL_W       = $clog2(PAGE_BYTES);
    localparam int HALF_BYTES  = MAIN_BYTES / 2;
    localparam int SPARE_BYTES = PAGE_BYTES - MAIN_BYTES;
    localparam int SPARE_W     = $clog2(SPARE_BYTES);
    localparam int LAST_COL    = PAGE_BYTES - 1;
    localparam int AC_W        = $clog2(PAGE_ADDR_CYC + 1);
    localparam logic [AC_W-1:0] PAGE_LAST  = AC_W'(PAGE_ADDR_CYC - 1);
    localparam logic [AC_W-1:0] BLOCK_LAST = AC_W'(BLOCK_ADDR_CYC - 1);

    phase_e          phase_q;
    busy_e           busy_q;
    outm_e           outm_q;
    region_e         region_q;
    logic [AC_W-1:0] acnt_q;
    logic [7:0]      first_q;
    logic [1:0]      id_idx_q;

    logic             busy, cmd_act, cmd_eff, addr_act, in_pgm;
    logic             go_pgm, go_ers, go_read, go_reset;
    logic             tmr_zero, finish, wp_abort;
    busy_e            start_kind;
    logic [CNT_W-1:0] start_len;
    logic [7:0]       first_byte;
    logic [COL_W-1:0] col_q, col_start;
    logic             col_adv, id_adv;
    logic             st_upd, st_val;
    logic [7:0]       stat_byte, arr_byte, id_byte;

    assign busy     = (busy_q != BK_NONE);
    assign rb_n     = ~busy;
    assign in_pgm   = (phase_q == PH_PROG_ADDR) || (phase_q == PH_PROG_DATA);
    assign cmd_act  = cmd_we && (!busy || allowed_when_busy(bus_in));
    assign cmd_eff  = cmd_act && !(bus_in == OPC_RESET && busy_q == BK_RESET);
    assign addr_act = addr_we && !busy;

    assign go_reset = cmd_eff && bus_in == OPC_RESET;
    assign go_pgm   = cmd_eff && bus_in == OPC_PGM_GO && phase_q == PH_PROG_DATA && wp_n;
    assign go_ers   = cmd_eff && bus_in == OPC_ERS_GO && phase_q == PH_ERASE_CONF && wp_n;
    assign go_read  = addr_act && phase_q == PH_READ_ADDR && acnt_q == PAGE_LAST;

    assign finish   = busy && tmr_zero && !go_reset;
    assign wp_abort = !wp_n && (busy_q == BK_PROG || busy_q == BK_ERASE) && !go_reset;

    always_comb begin
        start_kind = BK_NONE;
        start_len  = '0;
        if (go_reset) begin
            start_kind = BK_RESET;
            case (busy_q)
                BK_PROG:  start_len = CNT_W'(T_RST_PROG - 1);
                BK_ERASE: start_len = CNT_W'(T_RST_ERASE - 1);
                default:  start_len = CNT_W'(T_RST_READ - 1);
            endcase
        end else if (go_pgm) begin
            start_kind = BK_PROG;
            start_len  = CNT_W'(T_PROG - 1);
        end else if (go_ers) begin
            start_kind = BK_ERASE;
            start_len  = CNT_W'(T_ERASE - 1);
        end else if (go_read) begin
            start_kind = BK_READ;
            start_len  = CNT_W'(T_READ - 1);
        end
    end

    // start column: first address byte offset into the selected region
    assign first_byte = (acnt_q == '0) ? bus_in : first_q;
    always_comb begin
        case (region_q)
            RG_HIGH:  col_start = COL_W'(HALF_BYTES) + COL_W'(first_byte);
            RG_SPARE: col_start = COL_W'(MAIN_BYTES) + COL_W'(first_byte[SPARE_W-1:0]);
            default:  col_start = COL_W'(first_byte);
        endcase
    end

    assign col_adv = rd_en && !busy && outm_q == OM_READ;
    assign id_adv  = rd_en && !busy && outm_q == OM_ID && id_idx_q != 2'd2;

    assign st_upd = wp_abort || (finish && (busy_q == BK_PROG || busy_q == BK_ERASE));
    assign st_val = wp_abort ? 1'b1 : fail_inject;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            busy_q   <= BK_NONE;
            outm_q   <= OM_READ;
            region_q <= RG_LOW;
            acnt_q   <= '0;
            first_q  <= '0;
            id_idx_q <= '0;
        end else begin
            if (start_kind != BK_NONE)
                busy_q <= start_kind;
            else if (wp_abort || finish)
                busy_q <= BK_NONE;

            if (cmd_eff) begin
                if (in_pgm && bus_in != OPC_PGM_GO && bus_in != OPC_RESET) begin
                    phase_q <= PH_IDLE;
                end else begin
                    case (bus_in)
                        OPC_RD_LOW: begin
                            phase_q  <= PH_READ_ADDR;
                            acnt_q   <= '0;
                            region_q <= RG_LOW;
                            outm_q   <= OM_READ;
                        end
                        OPC_RD_HIGH: begin
                            phase_q  <= PH_READ_ADDR;
                            acnt_q   <= '0;
                            region_q <= RG_HIGH;
                        end
                        OPC_RD_SPARE: begin
                            phase_q  <= PH_READ_ADDR;
                            acnt_q   <= '0;
                            region_q <= RG_SPARE;
                        end
                        OPC_PGM_SETUP: begin
                            phase_q <= PH_PROG_ADDR;
                            acnt_q  <= '0;
                        end
                        OPC_ERS_SETUP: begin
                            phase_q <= PH_ERASE_ADDR;
                            acnt_q  <= '0;
                        end
                        OPC_IDENT:  phase_q <= PH_ID_ADDR;
                        OPC_STATUS: outm_q  <= OM_STATUS;
                        default:    phase_q <= PH_IDLE;
                    endcase
                end
            end else if (addr_act) begin
                case (phase_q)
                    PH_PROG_ADDR: begin
                        if (acnt_q == PAGE_LAST) phase_q <= PH_PROG_DATA;
                        else acnt_q <= acnt_q + 1'b1;
                    end
                    PH_ERASE_ADDR: begin
                        if (acnt_q == BLOCK_LAST) phase_q <= PH_ERASE_CONF;
                        else acnt_q <= acnt_q + 1'b1;
                    end
                    PH_READ_ADDR: begin
                        if (acnt_q == '0) first_q <= bus_in;
                        if (acnt_q == PAGE_LAST) begin
                            phase_q <= PH_IDLE;
                            outm_q  <= OM_READ;
                        end else begin
                            acnt_q <= acnt_q + 1'b1;
                        end
                    end
                    PH_ID_ADDR: begin
                        if (bus_in == 8'h00) begin
                            outm_q   <= OM_ID;
                            id_idx_q <= '0;
                        end
                        phase_q <= PH_IDLE;
                    end
                    default: ;
                endcase
            end

            if (id_adv)
                id_idx_q <= id_idx_q + 1'b1;
        end
    end

    flseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start_kind != BK_NONE),
        .load_val (start_len),
        .zero     (tmr_zero)
    );

    flseq_colptr #(.COL_W(COL_W), .LAST(LAST_COL)) u_col (
        .clk      (clk),
        .rst      (rst),
        .load     (go_read),
        .load_val (col_start),
        .adv      (col_adv),
        .col      (col_q)
    );

    flseq_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .clr       (go_reset),
        .upd       (st_upd),
        .upd_val   (st_val),
        .wp_n      (wp_n),
        .ready     (~busy),
        .stat_byte (stat_byte)
    );

    assign arr_byte = col_q[7:0] ^ 8'(col_q >> 8);
    assign id_byte  = (id_idx_q == 2'd0) ? IDENT_MAKER :
                      (id_idx_q == 2'd1) ? IDENT_DEVICE : 8'h00;

    always_comb begin
        case (outm_q)
            OM_STATUS: rd_data = stat_byte;
            OM_ID:     rd_data = id_byte;
            default:   rd_data = arr_byte;
        endcase
    end
endmodule

// File: rtl/flseq_chk.sv
module flseq_chk
    import flseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_we,
    input logic [7:0]       bus_in,
    input logic             wp_n,
    input logic             rb_n,
    input logic [7:0]       rd_data,
    input phase_e           phase_q,
    input busy_e            busy_q,
    input outm_e            outm_q,
    input logic [COL_W-1:0] col_q,
    input logic             tmr_zero,
    input logic [1:0]       id_idx_q
);
    p_prog_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PROG_DATA && cmd_we && bus_in == 8'h10 && wp_n) |=> !rb_n);

    p_col_frozen_busy_r5: assert property (@(posedge clk) disable iff (rst)
        !rb_n |=> $stable(col_q));

    p_discard_after_setup_r6: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_PROG_ADDR || phase_q == PH_PROG_DATA) && cmd_we &&
         bus_in != 8'h10 && bus_in != 8'hFF) |=> (phase_q == PH_IDLE && rb_n));

    p_status_fields_r7: assert property (@(posedge clk) disable iff (rst)
        (outm_q == OM_STATUS) |-> (rd_data[5:1] == 5'd0 && rd_data[7] == wp_n && rd_data[6] == rb_n));

    p_fail_masked_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (outm_q == OM_STATUS && !rb_n) |-> !rd_data[0]);

    p_reset_not_restarted_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_q == BK_RESET && !tmr_zero && cmd_we && bus_in == 8'hFF) |=> busy_q == BK_RESET);

    p_ident_first_r11: assert property (@(posedge clk) disable iff (rst)
        (outm_q == OM_ID && id_idx_q == 2'd0) |-> rd_data == 8'h98);

    p_wp_abort_r12: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && (busy_q == BK_PROG || busy_q == BK_ERASE) && !(cmd_we && bus_in == 8'hFF)) |=> rb_n);
endmodule

bind flseq_top flseq_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .bus_in   (bus_in),
    .wp_n     (wp_n),
    .rb_n     (rb_n),
    .rd_data  (rd_data),
    .phase_q  (phase_q),
    .busy_q   (busy_q),
    .outm_q   (outm_q),
    .col_q    (col_q),
    .tmr_zero (tmr_zero),
    .id_idx_q (id_idx_q)
);

// File: tb/tb_flseq_top.sv
module tb_flseq_top;
    localparam int TR  = 5;
    localparam int TP  = 20;
    localparam int TE  = 40;
    localparam int TRR = 3;
    localparam int TRP = 7;
    localparam int TRE = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0, addr_we = 1'b0, rd_en = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic       wp_n = 1'b1, fail_inject = 1'b0;
    logic [7:0] rd_data;
    logic       rb_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flseq_top #(
        .CNT_W(8), .T_READ(TR), .T_PROG(TP), .T_ERASE(TE),
        .T_RST_READ(TRR), .T_RST_PROG(TRP), .T_RST_ERASE(TRE)
    ) dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we), .bus_in(bus_in),
        .rd_en(rd_en), .wp_n(wp_n), .fail_inject(fail_inject),
        .rd_data(rd_data), .rb_n(rb_n)
    );

    function automatic logic [7:0] arr_val(int c);
        return 8'(c & 255) ^ 8'(c >> 8);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_we = 1'b1; bus_in = b;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic adr(input logic [7:0] b);
        addr_we = 1'b1; bus_in = b;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!rb_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic page_read(input logic [7:0] opc, input logic [7:0] a0, output int n);
        cmd(opc); adr(a0); adr(8'h00); adr(8'h00);
        busy_len(n);
    endtask

    task automatic pgm_start();
        cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00);
        cmd(8'h10);
    endtask

    task automatic ers_start();
        cmd(8'h60); adr(8'h20); adr(8'h00);
        cmd(8'hD0);
    endtask

    task automatic t_reset_state();
        chk("R1 rb_n after reset", rb_n, 1);
        chk("R1 read column 0 after reset", rd_data, 8'h00);
        cmd(8'h70);
        chk("R1/R7 status after reset", rd_data, 8'hC0);
        wp_n = 1'b0; #1;
        chk("R7 protect bit", rd_data, 8'h40);
        @(negedge clk);
        wp_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_read_modes();
        int n;
        page_read(8'h00, 8'h05, n);
        chk("R4 read transfer length", n, TR);
        chk("R4 low region start", rd_data, arr_val(5));
        rd();
        chk("R4 column advance", rd_data, arr_val(6));
        page_read(8'h01, 8'h05, n);
        chk("R4 high region start", rd_data, arr_val(261));
        page_read(8'h50, 8'h23, n);
        chk("R4 spare region start", rd_data, arr_val(515));
        page_read(8'h50, 8'h0E, n);
        rd(); rd();
        chk("R4 saturate at last column", rd_data, arr_val(527));
    endtask

    task automatic t_status_sticky();
        int n;
        page_read(8'h00, 8'h40, n);
        cmd(8'h70);
        chk("R8 status mode output", rd_data, 8'hC0);
        rd(); rd();
        cmd(8'h00);
        chk("R8 resume at unchanged column", rd_data, arr_val(64));
    endtask

    task automatic t_program();
        int n;
        fail_inject = 1'b0;
        pgm_start();
        busy_len(n);
        chk("R2 program busy length", n, TP);
        cmd(8'h70);
        chk("R2 pass status", rd_data, 8'hC0);
        fail_inject = 1'b1;
        pgm_start();
        busy_len(n);
        chk("R2 fail status", rd_data, 8'hC1);
        fail_inject = 1'b0;
    endtask

    task automatic t_busy_filter();
        int n;
        cmd(8'h00);
        pgm_start();
        cmd(8'h60); adr(8'h11); adr(8'h22); cmd(8'h00);
        busy_len(n);
        chk("R5 busy length unchanged by junk", n, TP - 4);
        chk("R5 column and mode untouched", rd_data, arr_val(64));
        pgm_start();
        cmd(8'h70);
        chk("R5/R7 status accepted while busy", rd_data, 8'h80);
        busy_len(n);
        chk("R5 busy length with status read", n, TP - 1);
    endtask

    task automatic t_cancel();
        cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00);
        cmd(8'h00);
        cmd(8'h10);
        chk("R6 cancelled program stays ready", rb_n, 1);
        chk("R6 discarded command left status mode", rd_data, 8'hC0);
    endtask

    task automatic t_erase();
        int n;
        cmd(8'hD0);
        chk("R3 lone confirm ignored", rb_n, 1);
        fail_inject = 1'b1;
        ers_start();
        busy_len(n);
        chk("R3 erase busy length", n, TE);
        chk("R3 erase fail status", rd_data, 8'hC1);
        fail_inject = 1'b0;
    endtask

    task automatic t_reset_times();
        int n;
        pgm_start();
        cmd(8'hFF);
        busy_len(n);
        chk("R9 reset during program", n, TRP);
        chk("R9 pass after reset", rd_data, 8'hC0);
        ers_start();
        cmd(8'hFF);
        busy_len(n);
        chk("R9 reset during erase", n, TRE);
        cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h00);
        cmd(8'hFF);
        busy_len(n);
        chk("R9 reset during read", n, TRR);
        cmd(8'hFF);
        busy_len(n);
        chk("R9 reset while idle", n, TRR);
    endtask

    task automatic t_reset_twice();
        int n;
        ers_start();
        cmd(8'hFF);
        cmd(8'hFF);
        busy_len(n);
        chk("R10 second reset ignored", n, TRE - 1);
        cmd(8'hFF);
        busy_len(n);
        chk("R10 later reset honoured", n, TRR);
    endtask

    task automatic t_ident();
        cmd(8'h90); adr(8'h00);
        chk("R11 maker byte", rd_data, 8'h98);
        rd();
        chk("R11 device byte", rd_data, 8'h73);
        rd();
        chk("R11 past the end", rd_data, 8'h00);
    endtask

    task automatic t_wp();
        cmd(8'h70);
        wp_n = 1'b0;
        @(negedge clk);
        pgm_start();
        chk("R12 protected program not started", rb_n, 1);
        chk("R12 protected status", rd_data, 8'h40);
        wp_n = 1'b1;
        ers_start();
        @(negedge clk);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R12 abort returns ready", rb_n, 1);
        chk("R12 abort sets fail", rd_data, 8'h41);
        wp_n = 1'b1; #1;
        chk("R12 fail kept after protect release", rd_data, 8'hC1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read_modes();
        t_status_sticky();
        t_program();
        t_busy_filter();
        t_cancel();
        t_erase();
        t_reset_times();
        t_reset_twice();
        t_ident();
        t_wp();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule